// File: doc/BRIEF.md
# Bit-Sliced Register and ALU Micro-Step Datapath

This block is the arithmetic core of a small 16-bit processor. The 16-bit word is assembled from four copies of one 4-bit slice. Each slice holds a 16-entry by 4-bit register file, a 4-bit adder-based ALU and a result multiplexer. The multiplexer returns either the ALU output or externally supplied load data to the register write port. Carries ripple from each slice into the next higher one. The lowest slice takes the carry-in implied by the operation.

Sixteen registers are addressable. Eight of them are visible to programs: indices 0 to 5 are general purpose, index 6 is the stack pointer and index 7 is the program counter. Indices 8 to 15 are internal. The microcode uses them for intermediate values of long operations, for effective-address arithmetic, and as alternate stack pointer and program counter copies for the privileged and unprivileged modes.

A control source outside the block sets the register addresses, the operation code, the write enable and the load data. It then pulses a step strobe. A micro step begins when that strobe falls. In that step the block reads operand A, combines it with the selected second operand in the ALU and, if enabled, writes the result back to register A at the closing clock edge. The step result and its zero and carry flags are held on the status outputs until the next step.

Top module: `slice_datapath`

## Requirements
- R1: After reset every register reads 0x0000, `result_o` is 0x0000, `zero_o` is 1 and `carry_o` is 0.
- R2: A step fires only on a clock edge where `strobe_i` was 1 at the previous edge and is 0 now. While the strobe is held steady, no register is written and `result_o`, `zero_o` and `carry_o` do not change.
- R3: Operation code 5 (load) places `load_i` on `result_o` and, with `we_i`=1, writes it into register `addr_a_i`. `carry_o` is 0.
- R4: Operation code 2 adds 2 to register `addr_a_i`, shows the sum on `result_o` and, with `we_i`=1, stores it back in the same register within that step. For example, program counter register 7 goes from 0xEA10 to 0xEA12.
- R5: Carries propagate across all four slices. Operation code 1 adds 1: 0x000F becomes 0x0010. Operation code 2 turns 0x0FFF into 0x1001, and turns 0xFFFE into 0x0000 with `carry_o`=1 and `zero_o`=1.
- R6: Operation code 3 produces A + B, where A is register `addr_a_i` and B is register `addr_b_i`. `carry_o` is the carry out of bit 15.
- R7: Operation code 4 produces A - B. `carry_o` is 1 when there is no borrow (A >= B) and 0 on a borrow.
- R8: With `we_i`=0, a step still updates the status outputs but leaves the register file unchanged.
- R9: All 16 registers, including the internal ones 8 to 15, hold independent values. Operation code 0 (pass) shows register A unchanged on `result_o`. Codes 6 and 7 behave as pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_i | input | 1 | Micro-step strobe; its falling transition starts a step |
| op_i | input | 3 | Operation code: 0 pass, 1 add 1, 2 add 2, 3 add, 4 subtract, 5 load |
| addr_a_i | input | 4 | Operand A register and write destination |
| addr_b_i | input | 4 | Operand B register |
| we_i | input | 1 | Write the step result back into register A |
| load_i | input | 16 | Data selected by the result multiplexer for the load operation |
| result_o | output | 16 | Result of the most recent step |
| zero_o | output | 1 | Result of the most recent step equals zero |
| carry_o | output | 1 | Carry out of the top slice for the most recent step |

## Verification
The strobe is registered once, so a step fires at the first rising edge after `strobe_i` is seen low following a high. The status outputs and the register write both take effect at that same edge. The bench drives every input on the falling clock edge, raises the strobe, lowers it one cycle later, and samples the status outputs one further falling edge later, half a cycle after the step edge. Register contents are confirmed afterwards through a separate pass step with writes disabled, which shows the stored value on `result_o` one cycle after its own strobe falls. The strobe-hold checks compare the outputs at each falling edge during the hold.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_INC1 = 3'd1,
    OP_INC2 = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_LOAD = 3'd5
  } dp_op_e;

endpackage

// File: rtl/dp_regfile_slice.sv
module dp_regfile_slice #(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  input  logic          wen,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [DEPTH];

  // write lands at the closing edge of the step; reads stay stable before it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wen) begin
      mem[raddr_a] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/dp_alu_slice.sv
module dp_alu_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  end

  assign sum  = wide[W-1:0];
  assign cout = wide[W];

endmodule

// File: rtl/dp_slice.sv
module dp_slice
  import dp_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dp_op_e        op,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic          wen,
  input  logic          cin,
  input  logic [W-1:0]  k_nib,
  input  logic [W-1:0]  ld_nib,
  output logic [W-1:0]  a_nib,
  output logic [W-1:0]  b_nib,
  output logic [W-1:0]  res_nib,
  output logic          cout
);

  logic [W-1:0] b_sel;
  logic [W-1:0] alu_sum;

  dp_regfile_slice #(.W(W), .DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .raddr_a (addr_a),
    .raddr_b (addr_b),
    .wen     (wen),
    .wdata   (res_nib),
    .rdata_a (a_nib),
    .rdata_b (b_nib)
  );

  // second ALU operand
  always_comb begin
    unique case (op)
      OP_ADD:           b_sel = b_nib;
      OP_SUB:           b_sel = ~b_nib;
      OP_INC1, OP_INC2: b_sel = k_nib;
      default:          b_sel = '0;
    endcase
  end

  dp_alu_slice #(.W(W)) u_alu (
    .a    (a_nib),
    .b    (b_sel),
    .cin  (cin),
    .sum  (alu_sum),
    .cout (cout)
  );

  // result multiplexer feeding the write port
  assign res_nib = (op == OP_LOAD) ? ld_nib : alu_sum;

endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import dp_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 4,
  parameter int NUM_REGS   = 16,
  localparam int DATA_W    = SLICE_W * NUM_SLICES,
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] load_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic              carry_o
);

  logic [1:0]        rst_sync;
  logic              rst_ns;
  logic              strobe_q;
  logic              step_fire;
  logic              wr_en;
  dp_op_e            op;
  logic [DATA_W-1:0] k_word;
  logic [NUM_SLICES:0] cy;
  logic [DATA_W-1:0] word_a;
  logic [DATA_W-1:0] word_b;
  logic [DATA_W-1:0] word_res;
  logic [DATA_W-1:0] res_d, res_q;
  logic              zero_d, zero_q;
  logic              carry_d, carry_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign step_fire = strobe_q & ~strobe_i;
  assign wr_en     = step_fire & we_i;
  assign op        = dp_op_e'(op_i);

  always_comb begin
    k_word = '0;
    if (op == OP_INC1) k_word = DATA_W'(1);
    if (op == OP_INC2) k_word = DATA_W'(2);
  end

  assign cy[0] = (op == OP_SUB);

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    dp_slice #(.W(SLICE_W), .DEPTH(NUM_REGS)) u_slice (
      .clk     (clk),
      .rst_n   (rst_ns),
      .op      (op),
      .addr_a  (addr_a_i),
      .addr_b  (addr_b_i),
      .wen     (wr_en),
      .cin     (cy[g]),
      .k_nib   (k_word[g*SLICE_W +: SLICE_W]),
      .ld_nib  (load_i[g*SLICE_W +: SLICE_W]),
      .a_nib   (word_a[g*SLICE_W +: SLICE_W]),
      .b_nib   (word_b[g*SLICE_W +: SLICE_W]),
      .res_nib (word_res[g*SLICE_W +: SLICE_W]),
      .cout    (cy[g+1])
    );
  end

  // status next state
  always_comb begin
    res_d   = res_q;
    zero_d  = zero_q;
    carry_d = carry_q;
    if (step_fire) begin
      res_d   = word_res;
      zero_d  = (word_res == '0);
      carry_d = (op == OP_LOAD) ? 1'b0 : cy[NUM_SLICES];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      res_q   <= '0;
      zero_q  <= 1'b1;
      carry_q <= 1'b0;
    end else begin
      res_q   <= res_d;
      zero_q  <= zero_d;
      carry_q <= carry_d;
    end
  end

  assign result_o = res_q;
  assign zero_o   = zero_q;
  assign carry_o  = carry_q;

endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              strobe,
  input logic [2:0]        op,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [DATA_W-1:0] ld,
  input logic [DATA_W-1:0] result,
  input logic              zero,
  input logic              carry
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(result) && $stable(zero) && $stable(carry)));

  assert_fire_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !strobe);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == 3'd5) |=> (result == $past(ld) && !carry));

  assert_inc2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == 3'd2) |=> ({carry, result} == $past({1'b0, opa} + (DATA_W+1)'(2))));

  assert_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == 3'd3) |=> ({carry, result} == $past({1'b0, opa} + {1'b0, opb})));

  assert_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == 3'd4) |=> (result == $past(opa - opb) && carry == $past(opa >= opb)));

endmodule

bind slice_datapath dp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_ns),
  .fire   (step_fire),
  .strobe (strobe_i),
  .op     (op_i),
  .opa    (word_a),
  .opb    (word_b),
  .ld     (load_i),
  .result (result_o),
  .zero   (zero_o),
  .carry  (carry_o)
);

// File: tb/slice_datapath_tb.sv
module slice_datapath_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe_i;
  logic [2:0]  op_i;
  logic [3:0]  addr_a_i;
  logic [3:0]  addr_b_i;
  logic        we_i;
  logic [15:0] load_i;
  logic [15:0] result_o;
  logic        zero_o;
  logic        carry_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  slice_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .op_i(op_i),
    .addr_a_i(addr_a_i), .addr_b_i(addr_b_i), .we_i(we_i), .load_i(load_i),
    .result_o(result_o), .zero_o(zero_o), .carry_o(carry_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // one micro step: strobe high for a cycle, then low; sample half a cycle after the step edge
  task automatic step(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b,
                      input logic we, input logic [15:0] ld);
    @(negedge clk);
    op_i = op; addr_a_i = a; addr_b_i = b; we_i = we; load_i = ld; strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input logic [3:0] a, input logic [15:0] v);
    step(3'd5, a, 4'd0, 1'b1, v);
  endtask

  task automatic read_reg(input string tag, input logic [3:0] a, input logic [15:0] exp);
    step(3'd0, a, 4'd0, 1'b0, 16'h0);
    check(tag, result_o, exp);
  endtask

  task automatic t_reset_r1();
    check("R1 result after reset", result_o, 16'h0);
    check("R1 zero after reset", zero_o, 1);
    check("R1 carry after reset", carry_o, 0);
    read_reg("R1 reg0 after reset", 4'd0, 16'h0);
    read_reg("R1 reg15 after reset", 4'd15, 16'h0);
  endtask

  task automatic t_strobe_r2();
    load(4'd3, 16'h1234);
    check("R3 load result", result_o, 16'h1234);
    check("R3 load carry", carry_o, 0);
    // hold low with a pending write
    @(negedge clk);
    op_i = 3'd5; addr_a_i = 4'd3; we_i = 1'b1; load_i = 16'hBEEF; strobe_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 strobe low hold", result_o, 16'h1234);
    end
    strobe_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 strobe high hold", result_o, 16'h1234);
    end
    // fall with write disabled: the step reads R3, which must not hold 0xBEEF
    op_i = 3'd0; we_i = 1'b0; strobe_i = 1'b0;
    @(negedge clk);
    check("R2 no write while held", result_o, 16'h1234);
  endtask

  task automatic t_pc_r4();
    load(4'd7, 16'hEA10);
    step(3'd2, 4'd7, 4'd0, 1'b1, 16'h0);
    check("R4 pc+2 result", result_o, 16'hEA12);
    check("R4 pc+2 carry", carry_o, 0);
    read_reg("R4 pc written back", 4'd7, 16'hEA12);
  endtask

  task automatic t_carry_r5();
    load(4'd1, 16'h000F);
    step(3'd1, 4'd1, 4'd0, 1'b1, 16'h0);
    check("R5 0x000F+1", result_o, 16'h0010);
    load(4'd2, 16'h0FFF);
    step(3'd2, 4'd2, 4'd0, 1'b1, 16'h0);
    check("R5 0x0FFF+2", result_o, 16'h1001);
    load(4'd4, 16'hFFFE);
    step(3'd2, 4'd4, 4'd0, 1'b1, 16'h0);
    check("R5 wrap result", result_o, 16'h0000);
    check("R5 wrap carry", carry_o, 1);
    check("R5 wrap zero", zero_o, 1);
  endtask

  task automatic t_add_r6();
    load(4'd5, 16'h7000);
    load(4'd6, 16'h9001);
    step(3'd3, 4'd5, 4'd6, 1'b1, 16'h0);
    check("R6 add overflow result", result_o, 16'h0001);
    check("R6 add overflow carry", carry_o, 1);
    check("R6 add zero flag", zero_o, 0);
    read_reg("R6 sum written", 4'd5, 16'h0001);
    load(4'd5, 16'h1234);
    load(4'd6, 16'h1111);
    step(3'd3, 4'd5, 4'd6, 1'b1, 16'h0);
    check("R6 add result", result_o, 16'h2345);
    check("R6 add no carry", carry_o, 0);
  endtask

  task automatic t_sub_r7();
    load(4'd8, 16'h0005);
    load(4'd9, 16'h0003);
    step(3'd4, 4'd8, 4'd9, 1'b1, 16'h0);
    check("R7 5-3 result", result_o, 16'h0002);
    check("R7 5-3 no borrow", carry_o, 1);
    load(4'd10, 16'h0003);
    load(4'd11, 16'h0005);
    step(3'd4, 4'd10, 4'd11, 1'b1, 16'h0);
    check("R7 3-5 result", result_o, 16'hFFFE);
    check("R7 3-5 borrow", carry_o, 0);
    step(3'd4, 4'd11, 4'd11, 1'b0, 16'h0);
    check("R7 equal zero", zero_o, 1);
    check("R7 equal carry", carry_o, 1);
  endtask

  task automatic t_nowrite_r8();
    load(4'd12, 16'h0100);
    step(3'd2, 4'd12, 4'd0, 1'b0, 16'h0);
    check("R8 status updates", result_o, 16'h0102);
    read_reg("R8 reg unchanged", 4'd12, 16'h0100);
  endtask

  task automatic t_regs_r9();
    for (int i = 0; i < 16; i++) load(4'(i), 16'hA0A0 ^ (16'(i) * 16'h0111));
    for (int i = 0; i < 16; i++)
      read_reg("R9 register independence", 4'(i), 16'hA0A0 ^ (16'(i) * 16'h0111));
    step(3'd6, 4'd14, 4'd0, 1'b0, 16'h0);
    check("R9 code 6 passes", result_o, 16'hA0A0 ^ (16'd14 * 16'h0111));
    step(3'd7, 4'd9, 4'd0, 1'b0, 16'h0);
    check("R9 code 7 passes", result_o, 16'hA0A0 ^ (16'd9 * 16'h0111));
  endtask

  initial begin
    rst_n = 1'b0; strobe_i = 1'b0; op_i = 3'd0; addr_a_i = 4'd0; addr_b_i = 4'd0;
    we_i = 1'b0; load_i = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_r1();
    t_strobe_r2();
    t_pc_r4();
    t_carry_r5();
    t_add_r6();
    t_sub_r7();
    t_nowrite_r8();
    t_regs_r9();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule